// File: doc/BRIEF.md
# Outbound Window Enable Decoder

This block decides whether a processor-side access that lands in the top sixteenth of a 32-bit address map is passed on to the PCI memory bus. That high region starts at 0xF0000000. It is cut into thirty-two equal windows of 8 MiB each. A window forwards only when two conditions hold. First, a two-bit forwarding mode field in a control register must hold the single value that switches forwarding on. Second, the window's own bit in an enable register must be set. The outbound side returns a hit flag and the index of the window that was hit.

The same block sorts the addresses that PCI bus masters present on the inbound side. Each address maps to one of four targets: main system memory, PCI memory, a small processor-local area, or no target at all. Both decoders are purely combinational from the current register contents. Software changes the enable and control registers through a simple write port and can read them back through a read port. Windows 0 and 31 are reserved and can never be opened.

Top module: `owd_window_decoder`

## Requirements
- R1: An outbound address whose top four bits are not 0xF gives hit=0 and window index 0.
- R2: When an outbound access hits, the window index equals (address - 0xF0000000) >> 23, that is, address bits [27:23].
- R3: Forwarding is globally on only when control register bits [8:7] equal binary 01. The values 00, 10 and 11 close every window, whatever the other control bits and the enable bits hold.
- R4: A write to the enable register (offset 0x060) stores the data ANDed with 0x7FFFFFFE, so bits 0 and 31 always read back as zero. Every other bit reads back as written.
- R5: Window 0 (0xF0000000–0xF07FFFFF) and window 31 (0xFF800000–0xFFFFFFFF) never give a hit.
- R6: The control register (offset 0x038) reads back all 32 bits as written. A read of any offset other than 0x038 or 0x060 returns zero. A write to any other offset changes neither register.
- R7: An outbound access in the region whose window bit is clear gives hit=0 and window index 0. A register write takes effect on the decode outputs from the clock edge that captures it.
- R8: Inbound addresses below 0xF0800000 give region code 1 (system memory).
- R9: Inbound addresses from 0xF0800000 to 0xFF7FFFFF give region code 2 (PCI memory).
- R10: Inbound addresses from 0xFFF00000 to 0xFFFFEFFF give region code 3 (processor-local).
- R11: All other inbound addresses (0xFF800000–0xFFEFFFFF and 0xFFFFF000–0xFFFFFFFF) give region code 0 (no target).
- R12: After reset both registers read zero and every window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 12 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| ob_addr | input | 32 | Outbound (processor-side) address |
| ob_hit | output | 1 | Outbound access is forwarded |
| ob_win | output | 5 | Index of the window hit, zero on a miss |
| ib_addr | input | 32 | Inbound (bus-master) address |
| ib_region | output | 2 | Inbound target: 0 none, 1 system, 2 PCI, 3 processor-local |

## Verification
The bench sends the window edges at 0xF0800000 and 0xFF7FFFFF and the reserved windows at both ends of the region to the outbound decoder. A decoder with an off-by-one window base would report the wrong index at these points, and one that dropped the enable mask would open window 0 or 31. Each mode value that is not 01 is tried with the enable register full, and 01 is tried with every other control bit set. A decoder that tested one mode bit, or the whole register, would then forward when it should not or stay closed. The inbound checks sit on both sides of every range boundary, including the gap below 0xFFF00000 and the last page below 0xFFFFFFFF. A wrong comparison limit shows up there as a wrong region code. The bench also writes to an unmapped offset and reads it back, which exposes a decoder that matched offsets on too few address bits.

// File: rtl/owd_pkg.sv
package owd_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_SYS  = 2'd1,
      RGN_PCI  = 2'd2,
      RGN_CPU  = 2'd3
   } rgn_e;

   localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/owd_regs.sv
module owd_regs #(
   parameter int unsigned        DATA_W   = 32,
   parameter int unsigned        RA_W     = 12,
   parameter logic [RA_W-1:0]    EN_OFS   = 12'h060,
   parameter logic [RA_W-1:0]    CTRL_OFS = 12'h038,
   parameter logic [DATA_W-1:0]  EN_MASK  = 32'h7FFF_FFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [RA_W-1:0]   waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RA_W-1:0]   raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] en_q,
   output logic [DATA_W-1:0] ctrl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         ctrl_q <= '0;
      end else if (wr) begin
         if (waddr == EN_OFS)   en_q   <= wdata & EN_MASK;
         if (waddr == CTRL_OFS) ctrl_q <= wdata;
      end
   end

   always_comb begin
      if (raddr == EN_OFS)        rdata = en_q;
      else if (raddr == CTRL_OFS) rdata = ctrl_q;
      else                        rdata = '0;
   end

endmodule

// File: rtl/owd_outbound.sv
module owd_outbound #(
   parameter int unsigned            ADDR_W      = 32,
   parameter int unsigned            WIN_SHIFT   = 23,
   parameter int unsigned            IDX_W       = 5,
   parameter int unsigned            REGION_BITS = 4,
   parameter logic [REGION_BITS-1:0] REGION_TAG  = 4'hF,
   parameter int unsigned            STYLE       = 0,
   localparam int unsigned           NUM_WIN     = 1 << IDX_W
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_WIN-1:0] win_en,
   input  logic               fwd_on,
   output logic               hit,
   output logic [IDX_W-1:0]   win
);

   logic             in_rgn;
   logic [IDX_W-1:0] idx;

   assign in_rgn = (addr[ADDR_W-1 -: REGION_BITS] == REGION_TAG);
   assign idx    = addr[WIN_SHIFT +: IDX_W];

   generate
      if (STYLE == 0) begin : g_onehot
         logic [NUM_WIN-1:0] sel;
         for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            assign sel[g] = in_rgn & fwd_on & win_en[g] & (idx == IDX_W'(g));
         end
         always_comb begin
            win = '0;
            for (int i = 0; i < NUM_WIN; i++) begin
               if (sel[i]) win = win | IDX_W'(i);
            end
         end
         assign hit = |sel;
      end else begin : g_index
         logic open_w;
         assign open_w = in_rgn & fwd_on & win_en[idx];
         assign hit    = open_w;
         assign win    = open_w ? idx : '0;
      end
   endgenerate

endmodule

// File: rtl/owd_inbound.sv
module owd_inbound
   import owd_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 32,
   parameter logic [ADDR_W-1:0] PCI_LO  = 32'hF080_0000,
   parameter logic [ADDR_W-1:0] PCI_END = 32'hFF80_0000,
   parameter logic [ADDR_W-1:0] CPU_LO  = 32'hFFF0_0000,
   parameter logic [ADDR_W-1:0] CPU_HI  = 32'hFFFF_EFFF
) (
   input  logic [ADDR_W-1:0] addr,
   output rgn_e              region
);

   always_comb begin
      if (addr < PCI_LO)                        region = RGN_SYS;
      else if (addr < PCI_END)                  region = RGN_PCI;
      else if (addr >= CPU_LO && addr <= CPU_HI) region = RGN_CPU;
      else                                      region = RGN_NONE;
   end

endmodule

// File: rtl/owd_window_decoder.sv
module owd_window_decoder
   import owd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RA_W        = 12,
   parameter int unsigned WIN_SHIFT   = 23,
   parameter int unsigned REGION_BITS = 4,
   parameter int unsigned MODE_LSB    = 7,
   parameter int unsigned STYLE       = 0,
   parameter logic [ADDR_W-1:0] CPU_LO = 32'hFFF0_0000,
   parameter logic [ADDR_W-1:0] CPU_HI = 32'hFFFF_EFFF,
   localparam int unsigned IDX_W      = ADDR_W - REGION_BITS - WIN_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [RA_W-1:0]   reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [ADDR_W-1:0] ob_addr,
   output logic              ob_hit,
   output logic [IDX_W-1:0]  ob_win,
   input  logic [ADDR_W-1:0] ib_addr,
   output logic [1:0]        ib_region
);

   localparam int unsigned              NUM_WIN     = 1 << IDX_W;
   localparam logic [REGION_BITS-1:0]   REGION_TAG  = '1;
   localparam logic [ADDR_W-1:0]        REGION_BASE = {REGION_TAG, {(ADDR_W-REGION_BITS){1'b0}}};
   localparam logic [ADDR_W-1:0]        WIN_SIZE    = ADDR_W'(1) << WIN_SHIFT;
   localparam logic [ADDR_W-1:0]        PCI_LO      = REGION_BASE + WIN_SIZE;
   localparam logic [ADDR_W-1:0]        PCI_END     = REGION_BASE + ADDR_W'(NUM_WIN-1) * WIN_SIZE;
   localparam logic [DATA_W-1:0]        EN_MASK     = ~(DATA_W'(1) | (DATA_W'(1) << (NUM_WIN-1)));
   localparam logic [MODE_W-1:0]        MODE_ON     = MODE_W'(1);
   localparam logic [RA_W-1:0]          EN_OFS      = RA_W'(12'h060);
   localparam logic [RA_W-1:0]          CTRL_OFS    = RA_W'(12'h038);

   generate
      if (IDX_W < 2 || NUM_WIN > DATA_W) begin : g_bad_geom
         $error("window count must be between 4 and the register width");
      end
      if (MODE_LSB + MODE_W > DATA_W) begin : g_bad_mode
         $error("mode field lies outside the control register");
      end
      if (STYLE > 1) begin : g_bad_style
         $error("STYLE must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] ctrl_q;
   logic              fwd_on;
   rgn_e              ib_rgn;

   owd_regs #(
      .DATA_W  (DATA_W),
      .RA_W    (RA_W),
      .EN_OFS  (EN_OFS),
      .CTRL_OFS(CTRL_OFS),
      .EN_MASK (EN_MASK)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .waddr (reg_waddr),
      .wdata (reg_wdata),
      .raddr (reg_raddr),
      .rdata (reg_rdata),
      .en_q  (en_q),
      .ctrl_q(ctrl_q)
   );

   assign fwd_on = (ctrl_q[MODE_LSB +: MODE_W] == MODE_ON);

   owd_outbound #(
      .ADDR_W     (ADDR_W),
      .WIN_SHIFT  (WIN_SHIFT),
      .IDX_W      (IDX_W),
      .REGION_BITS(REGION_BITS),
      .REGION_TAG (REGION_TAG),
      .STYLE      (STYLE)
   ) u_out (
      .addr  (ob_addr),
      .win_en(en_q[NUM_WIN-1:0]),
      .fwd_on(fwd_on),
      .hit   (ob_hit),
      .win   (ob_win)
   );

   owd_inbound #(
      .ADDR_W (ADDR_W),
      .PCI_LO (PCI_LO),
      .PCI_END(PCI_END),
      .CPU_LO (CPU_LO),
      .CPU_HI (CPU_HI)
   ) u_in (
      .addr  (ib_addr),
      .region(ib_rgn)
   );

   assign ib_region = ib_rgn;

endmodule

// File: rtl/owd_checker.sv
module owd_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RA_W   = 12,
   parameter int unsigned IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [RA_W-1:0]   reg_waddr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] en_q,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [ADDR_W-1:0] ob_addr,
   input logic              ob_hit,
   input logic [IDX_W-1:0]  ob_win,
   input logic [ADDR_W-1:0] ib_addr,
   input logic [1:0]        ib_region
);

   AST_OUTSIDE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_addr[ADDR_W-1 -: 4] != 4'hF) |-> (!ob_hit && ob_win == '0)); // R1

   AST_HIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      ob_hit |-> (ob_win == ob_addr[ADDR_W-5 -: IDX_W])); // R2

   AST_HIT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      ob_hit |-> (ctrl_q[8:7] == 2'b01)); // R3

   AST_ENABLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_waddr == 12'h060) |=> (en_q == ($past(reg_wdata) & 32'h7FFF_FFFE))); // R4

   AST_EDGE_WINDOWS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      ob_hit |-> (ob_win != '0 && ob_win != '1)); // R5

   AST_MISS_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      !ob_hit |-> (ob_win == '0)); // R7

   AST_LOW_IS_SYSTEM: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_addr < 32'hF080_0000) |-> (ib_region == 2'd1)); // R8

endmodule

bind owd_window_decoder owd_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .RA_W  (RA_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_waddr(reg_waddr),
   .reg_wdata(reg_wdata),
   .en_q     (en_q),
   .ctrl_q   (ctrl_q),
   .ob_addr  (ob_addr),
   .ob_hit   (ob_hit),
   .ob_win   (ob_win),
   .ib_addr  (ib_addr),
   .ib_region(ib_region)
);

// File: tb/test_owd_window_decoder.sv
`timescale 1ns/1ps
module test_owd_window_decoder;

   localparam real PERIOD = 8.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [11:0] reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic [31:0] ob_addr = 32'h0;
   logic        ob_hit;
   logic [4:0]  ob_win;
   logic [31:0] ib_addr = 32'h0;
   logic [1:0]  ib_region;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      int          kind;   // 0 outbound, 1 inbound, 2 register read
      logic [31:0] stim;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];

   always #(PERIOD/2) clk = ~clk;

   owd_window_decoder i_owd_window_decoder (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr),
      .reg_rdata(reg_rdata),
      .ob_addr  (ob_addr),
      .ob_hit   (ob_hit),
      .ob_win   (ob_win),
      .ib_addr  (ib_addr),
      .ib_region(ib_region)
   );

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic chk_ob(input logic [31:0] a, input logic h, input logic [4:0] w, input string tag);
      item_t it;
      @(negedge clk);
      ob_addr = a;
      it.kind = 0; it.stim = a; it.exp = {26'b0, h, w}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_ib(input logic [31:0] a, input logic [1:0] r, input string tag);
      item_t it;
      @(negedge clk);
      ib_addr = a;
      it.kind = 1; it.stim = a; it.exp = {30'b0, r}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_rd(input logic [11:0] a, input logic [31:0] d, input string tag);
      item_t it;
      @(negedge clk);
      reg_raddr = a;
      it.kind = 2; it.stim = {20'b0, a}; it.exp = d; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compares queued expectations after the inputs settle
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
               0:       act = {26'b0, ob_hit, ob_win};
               1:       act = {30'b0, ib_region};
               default: act = reg_rdata;
            endcase
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s stim=%h actual=%h expected=%h", it.tag, it.stim, act, it.exp);
            end
         end
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      chk_rd(12'h060, 32'h0, "R12 enable after reset");
      chk_rd(12'h038, 32'h0, "R12 control after reset");
      chk_ob(32'hF080_0000, 1'b0, 5'd0, "R12 window closed after reset");

      wr(12'h038, 32'h0000_0080);
      wr(12'h060, 32'hFFFF_FFFF);
      chk_rd(12'h060, 32'h7FFF_FFFE, "R4 enable mask");
      chk_rd(12'h038, 32'h0000_0080, "R6 control readback");

      // R2 window index
      chk_ob(32'hF080_0000, 1'b1, 5'd1,  "R2 first open window");
      chk_ob(32'hFF7F_FFFF, 1'b1, 5'd30, "R2 last open window");
      chk_ob(32'hF512_3456, 1'b1, 5'd10, "R2 mid window");
      // R5 reserved windows
      chk_ob(32'hF000_0000, 1'b0, 5'd0, "R5 window 0");
      chk_ob(32'hF07F_FFFF, 1'b0, 5'd0, "R5 window 0 top");
      chk_ob(32'hFF80_0000, 1'b0, 5'd0, "R5 window 31");
      chk_ob(32'hFFFF_FFFF, 1'b0, 5'd0, "R5 window 31 top");
      // R1 outside region
      chk_ob(32'hEFFF_FFFF, 1'b0, 5'd0, "R1 below region");
      chk_ob(32'h0080_0000, 1'b0, 5'd0, "R1 low address");

      // R3 mode field
      wr(12'h038, 32'h0000_0000);
      chk_ob(32'hF080_0000, 1'b0, 5'd0, "R3 mode 00");
      wr(12'h038, 32'h0000_0100);
      chk_ob(32'hF080_0000, 1'b0, 5'd0, "R3 mode 10");
      wr(12'h038, 32'h0000_0180);
      chk_ob(32'hF080_0000, 1'b0, 5'd0, "R3 mode 11");
      wr(12'h038, 32'hFFFF_FEFF);
      chk_ob(32'hF080_0000, 1'b1, 5'd1, "R3 mode 01 other bits set");
      chk_rd(12'h038, 32'hFFFF_FEFF, "R6 control full readback");

      // R7 sparse enable, takes effect after write edge
      wr(12'h060, 32'h0000_0404);
      chk_rd(12'h060, 32'h0000_0404, "R4 sparse enable readback");
      chk_ob(32'hF100_0000, 1'b1, 5'd2,  "R7 window 2 open");
      chk_ob(32'hF180_0000, 1'b0, 5'd0,  "R7 window 3 closed");
      chk_ob(32'hF500_0000, 1'b1, 5'd10, "R7 window 10 open");

      wr(12'h060, 32'h8000_0001);
      chk_rd(12'h060, 32'h0, "R4 edge bits dropped");
      chk_ob(32'hF000_0000, 1'b0, 5'd0, "R5 window 0 after edge write");

      // R6 unmapped offset
      wr(12'h040, 32'hFFFF_FFFF);
      chk_rd(12'h060, 32'h0, "R6 enable untouched by stray write");
      chk_rd(12'h038, 32'hFFFF_FEFF, "R6 control untouched by stray write");
      chk_rd(12'h040, 32'h0, "R6 unmapped read");

      // inbound classification
      chk_ib(32'h0000_0000, 2'd1, "R8 zero");
      chk_ib(32'hF07F_FFFF, 2'd1, "R8 top of system");
      chk_ib(32'hF080_0000, 2'd2, "R9 base of PCI");
      chk_ib(32'hFF7F_FFFF, 2'd2, "R9 top of PCI");
      chk_ib(32'hFF80_0000, 2'd0, "R11 gap start");
      chk_ib(32'hFFEF_FFFF, 2'd0, "R11 gap end");
      chk_ib(32'hFFF0_0000, 2'd3, "R10 base of local");
      chk_ib(32'hFFFF_EFFF, 2'd3, "R10 top of local");
      chk_ib(32'hFFFF_F000, 2'd0, "R11 last page");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule